// File: doc/BRIEF.md
# HDMI Transmitter Bring-Up Sequencer

This block takes an HDMI transmitter from power-on to a configured state without any processor involvement. After its own reset it holds the transmitter in reset for a fixed number of clocks, waits a settle interval, and then issues a fixed sequence of single-byte register commands to a byte-level I2C master through a start/done command port. The sequence unlocks the high-level register mode, polls the identity register until the device answers, powers the device up, enables source termination through a paged read-modify-write of an internal register, sets the PLL bandwidth through the same paged path, and finally writes a parameter-supplied video setup list.

The setup list is written in an order that respects how the device latches its settings: a free list of offset/value pairs first, then the input and output format bytes, then the fourteen-byte picture-information block at offsets 0x0C to 0x19 in ascending order (whose last byte commits the format), and finally a rewrite of the sync control byte at offset 0x63, which the device requires after 0x19 has been written. Every command goes to the 8-bit device address 0x72. The block reports busy, done and error, and on error a code naming the step that failed.

Top module: `hdmi_tx_bringup`

## Requirements
- R1: After reset is released, `dev_rst_n` stays low for exactly RST_CYC clock cycles, then stays high for exactly SETTLE_CYC cycles before the first `cmd_start`; no command is issued while `dev_rst_n` is low.
- R2: Every command uses device address 0x72, and the first command is a write (`cmd_rd`=0) of 0x00 to offset 0xC7.
- R3: The second step reads offset 0x1B and repeats the read until it returns 0xB4, issuing at most ID_TRIES reads; if ID_TRIES reads all return another value, the block stops with error code 2.
- R4: After identification, 0x00 is written to offset 0x1E.
- R5: Termination step: write 0x01 to 0xBC, write 0x82 to 0xBD, read 0xBE, then write to 0xBE the value read with bit 0 set.
- R6: PLL step: write 0x01 to 0xBC, write 0x80 to 0xBD, write 0x24 to 0xBE.
- R7: Then, in this order: the PRE_TABLE pairs (entry i in bits [16i+15:16i], offset in the high byte), FMT_IN to 0x09, FMT_OUT to 0x0A, byte k of AVI_BYTES (bits [8k+7:8k]) to offset 0x0C+k for k = 0..13, and SYNC_CTRL to 0x63.
- R8: `cmd_start` is a one-cycle pulse; no new start is issued until `cmd_done` has answered the previous one, and `cmd_offs`, `cmd_wdata` and `cmd_rd` stay stable while a command is outstanding.
- R9: A `cmd_done` with `cmd_nack` set stops the sequence with `err` high and no further commands; `err_step` names the step: 1 unlock, 2 identity, 3 power, 4 termination, 5 PLL, 6 free list, 7 format bytes, 8 picture-information block, 9 sync rewrite.
- R10: `busy` is high from reset until the sequence ends; then exactly one of `done` or `err` goes high and both hold until the next reset, with `err_step` = 0 on success.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_rst_n | output | 1 | Active-low reset to the transmitter |
| cmd_dev | output | 8 | Device address of the command |
| cmd_offs | output | 8 | Register offset of the command |
| cmd_wdata | output | 8 | Write data of the command |
| cmd_rd | output | 1 | 1 = read, 0 = write |
| cmd_start | output | 1 | One-cycle command request |
| cmd_done | input | 1 | One-cycle command completion |
| cmd_nack | input | 1 | Ack error, valid with cmd_done |
| cmd_rdata | input | 8 | Read data, valid with cmd_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully |
| err | output | 1 | Sequence stopped on a failure |
| err_step | output | 4 | Code of the failed step |

## Verification
The bench runs the whole sequence against a behavioural device model and compares the complete command log with a list it builds from the requirements. Identity answers are varied from immediate success, through success on the last allowed read, to exhaustion, which separates the retry count from the error exit. The termination register is preset to several values so the read-modify-write is seen to set only bit 0, and an ack error is injected at every command position in turn, which tells apart the step codes and shows that nothing is issued after a failure.

// File: rtl/txinit_pkg.sv
package txinit_pkg;

    localparam logic [7:0] DEV_ADDR = 8'h72;
    localparam logic [7:0] ID_VALUE = 8'hB4;

    typedef enum logic [2:0] {
        PH_RESET,
        PH_SETTLE,
        PH_ISSUE,
        PH_WAIT,
        PH_DONE,
        PH_FAIL
    } phase_e;

    typedef enum logic [3:0] {
        ST_NONE   = 4'd0,
        ST_UNLOCK = 4'd1,
        ST_IDENT  = 4'd2,
        ST_POWER  = 4'd3,
        ST_TERM   = 4'd4,
        ST_PLL    = 4'd5,
        ST_PRE    = 4'd6,
        ST_FMT    = 4'd7,
        ST_AVI    = 4'd8,
        ST_SYNC   = 4'd9
    } step_e;

    typedef struct packed {
        logic       rd;
        logic [7:0] offs;
        logic [7:0] data;
        logic       capture;
        logic       ident;
        step_e      step;
    } op_t;

    function automatic op_t mk_op(input logic rd, input logic [7:0] offs,
                                  input logic [7:0] data, input step_e step);
        op_t o;
        o.rd      = rd;
        o.offs    = offs;
        o.data    = data;
        o.capture = 1'b0;
        o.ident   = 1'b0;
        o.step    = step;
        return o;
    endfunction

endpackage

// File: rtl/txinit_timer.sv
module txinit_timer #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= INIT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R1: the delay counter steps down by one each cycle until it is empty
    p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/txinit_oplist.sv
module txinit_oplist
    import txinit_pkg::*;
#(
    parameter int                    N_PRE     = 4,
    parameter int                    OPW       = 5,
    parameter logic [N_PRE*16-1:0]   PRE_TABLE = '0,
    parameter logic [7:0]            FMT_IN    = 8'h00,
    parameter logic [7:0]            FMT_OUT   = 8'h00,
    parameter logic [14*8-1:0]       AVI_BYTES = '0,
    parameter logic [7:0]            SYNC_CTRL = 8'h00
) (
    input  logic [OPW-1:0] op_idx,
    input  logic [7:0]     cap,
    output op_t            op
);

    localparam int L_PRE0 = 10;
    localparam int L_FMT0 = L_PRE0 + N_PRE;
    localparam int L_AVI0 = L_FMT0 + 2;
    localparam int L_SYNC = L_AVI0 + 14;

    int          idx;
    logic [15:0] pre_ent;
    logic [7:0]  avi_byte;

    always_comb begin
        idx      = int'(op_idx);
        pre_ent  = '0;
        avi_byte = '0;
        op       = mk_op(1'b0, 8'h00, 8'h00, ST_NONE);
        if (idx == 0) begin
            op = mk_op(1'b0, 8'hC7, 8'h00, ST_UNLOCK);
        end else if (idx == 1) begin
            op       = mk_op(1'b1, 8'h1B, 8'h00, ST_IDENT);
            op.ident = 1'b1;
        end else if (idx == 2) begin
            op = mk_op(1'b0, 8'h1E, 8'h00, ST_POWER);
        end else if (idx == 3) begin
            op = mk_op(1'b0, 8'hBC, 8'h01, ST_TERM);
        end else if (idx == 4) begin
            op = mk_op(1'b0, 8'hBD, 8'h82, ST_TERM);
        end else if (idx == 5) begin
            op         = mk_op(1'b1, 8'hBE, 8'h00, ST_TERM);
            op.capture = 1'b1;
        end else if (idx == 6) begin
            op = mk_op(1'b0, 8'hBE, cap | 8'h01, ST_TERM);
        end else if (idx == 7) begin
            op = mk_op(1'b0, 8'hBC, 8'h01, ST_PLL);
        end else if (idx == 8) begin
            op = mk_op(1'b0, 8'hBD, 8'h80, ST_PLL);
        end else if (idx == 9) begin
            op = mk_op(1'b0, 8'hBE, 8'h24, ST_PLL);
        end else if (idx < L_FMT0) begin
            pre_ent = PRE_TABLE[(idx - L_PRE0)*16 +: 16];
            op      = mk_op(1'b0, pre_ent[15:8], pre_ent[7:0], ST_PRE);
        end else if (idx == L_FMT0) begin
            op = mk_op(1'b0, 8'h09, FMT_IN, ST_FMT);
        end else if (idx == L_FMT0 + 1) begin
            op = mk_op(1'b0, 8'h0A, FMT_OUT, ST_FMT);
        end else if (idx < L_SYNC) begin
            avi_byte = AVI_BYTES[(idx - L_AVI0)*8 +: 8];
            op       = mk_op(1'b0, 8'h0C + 8'(idx - L_AVI0), avi_byte, ST_AVI);
        end else begin
            op = mk_op(1'b0, 8'h63, SYNC_CTRL, ST_SYNC);
        end
    end

    // R7: the format bytes are never issued from a slot after the picture block
    always_comb begin
        if (idx >= L_AVI0) begin
            p_fmt_before_avi_r7: assert (op.offs != 8'h09 || op.step != ST_FMT);
        end
    end

endmodule

// File: rtl/hdmi_tx_bringup.sv
module hdmi_tx_bringup
    import txinit_pkg::*;
#(
    parameter int                    RST_CYC    = 64,
    parameter int                    SETTLE_CYC = 1000,
    parameter int                    ID_TRIES   = 8,
    parameter int                    N_PRE      = 4,
    parameter logic [N_PRE*16-1:0]   PRE_TABLE  = {16'h1A01, 16'h6004, 16'h0B00, 16'h0870},
    parameter logic [7:0]            FMT_IN     = 8'h00,
    parameter logic [7:0]            FMT_OUT    = 8'h00,
    parameter logic [14*8-1:0]       AVI_BYTES  = '0,
    parameter logic [7:0]            SYNC_CTRL  = 8'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       dev_rst_n,
    output logic [7:0] cmd_dev,
    output logic [7:0] cmd_offs,
    output logic [7:0] cmd_wdata,
    output logic       cmd_rd,
    output logic       cmd_start,
    input  logic       cmd_done,
    input  logic       cmd_nack,
    input  logic [7:0] cmd_rdata,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [3:0] err_step
);

    localparam int N_OPS = 10 + N_PRE + 2 + 14 + 1;
    localparam int OPW   = $clog2(N_OPS);
    localparam int TRW   = $clog2(ID_TRIES + 1);
    localparam int TMAX  = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam int TW    = $clog2(TMAX + 1);

    typedef struct packed {
        phase_e         phase;
        logic [OPW-1:0] op;
        logic [TRW-1:0] tries;
        logic [7:0]     cap;
        step_e          code;
    } state_t;

    state_t        s_d, s_q;
    op_t           cur;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_exp;

    txinit_timer #(
        .W    (TW),
        .INIT (TW'(RST_CYC - 1))
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    txinit_oplist #(
        .N_PRE     (N_PRE),
        .OPW       (OPW),
        .PRE_TABLE (PRE_TABLE),
        .FMT_IN    (FMT_IN),
        .FMT_OUT   (FMT_OUT),
        .AVI_BYTES (AVI_BYTES),
        .SYNC_CTRL (SYNC_CTRL)
    ) u_ops (
        .op_idx (s_q.op),
        .cap    (s_q.cap),
        .op     (cur)
    );

    always_comb begin
        s_d    = s_q;
        t_load = 1'b0;
        t_val  = TW'(SETTLE_CYC - 1);
        unique case (s_q.phase)
            PH_RESET: begin
                if (t_exp) begin
                    t_load    = 1'b1;
                    s_d.phase = PH_SETTLE;
                end
            end
            PH_SETTLE: begin
                if (t_exp) begin
                    s_d.phase = PH_ISSUE;
                end
            end
            PH_ISSUE: begin
                s_d.phase = PH_WAIT;
            end
            PH_WAIT: begin
                if (cmd_done) begin
                    if (cmd_nack) begin
                        s_d.phase = PH_FAIL;
                        s_d.code  = cur.step;
                    end else if (cur.ident && cmd_rdata != ID_VALUE) begin
                        if (s_q.tries == TRW'(ID_TRIES - 1)) begin
                            s_d.phase = PH_FAIL;
                            s_d.code  = ST_IDENT;
                        end else begin
                            s_d.tries = s_q.tries + 1'b1;
                            s_d.phase = PH_ISSUE;
                        end
                    end else begin
                        if (cur.capture) begin
                            s_d.cap = cmd_rdata;
                        end
                        if (s_q.op == OPW'(N_OPS - 1)) begin
                            s_d.phase = PH_DONE;
                        end else begin
                            s_d.op    = s_q.op + 1'b1;
                            s_d.phase = PH_ISSUE;
                        end
                    end
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_RESET, op: '0, tries: '0, cap: '0, code: ST_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign dev_rst_n = (s_q.phase != PH_RESET);
    assign cmd_dev   = DEV_ADDR;
    assign cmd_offs  = cur.offs;
    assign cmd_wdata = cur.data;
    assign cmd_rd    = cur.rd;
    assign cmd_start = (s_q.phase == PH_ISSUE);
    assign done      = (s_q.phase == PH_DONE);
    assign err       = (s_q.phase == PH_FAIL);
    assign busy      = !(done || err);
    assign err_step  = s_q.code;

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_q | cmd_start;
        end
    end

    // R1: no command while the transmitter is held in reset
    p_no_cmd_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> dev_rst_n);

    // R2: the very first command is the mode-unlock write
    p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !seen_q) |-> (cmd_offs == 8'hC7 && !cmd_rd && cmd_wdata == 8'h00));

    // R8: start is a single-cycle pulse
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    // R8: command fields hold while the command is outstanding
    p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_WAIT && !cmd_done) |=>
            ($stable(cmd_offs) && $stable(cmd_wdata) && $stable(cmd_rd)));

    // R9: nothing is issued once the sequence has ended
    p_quiet_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !cmd_start);

    // R9: an ack error always ends in the failure state
    p_nack_fails_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_WAIT && cmd_done && cmd_nack) |=> (err && err_step != 4'd0));

    // R10: end states are exclusive and sticky
    p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    p_sticky_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> ($stable(done) && $stable(err) && $stable(err_step)));

endmodule

// File: tb/hdmi_tx_bringup_tb.sv
module hdmi_tx_bringup_tb;

    localparam int RST   = 4;
    localparam int SET   = 3;
    localparam int TRIES = 3;
    localparam int NPRE  = 2;
    localparam logic [NPRE*16-1:0] PRE = {16'h0B00, 16'h0870};
    localparam logic [7:0] FIN   = 8'h00;
    localparam logic [7:0] FOUT  = 8'h10;
    localparam logic [7:0] SYNCV = 8'h40;

    function automatic logic [111:0] avi_fill();
        logic [111:0] v;
        for (int k = 0; k < 14; k++) v[k*8 +: 8] = 8'hA0 + 8'(k);
        return v;
    endfunction
    localparam logic [111:0] AVI = avi_fill();

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_rst_n, cmd_rd, cmd_start, busy, done, err;
    logic [7:0] cmd_dev, cmd_offs, cmd_wdata;
    logic       cmd_done = 1'b0, cmd_nack = 1'b0;
    logic [7:0] cmd_rdata = 8'h00;
    logic [3:0] err_step;

    always #2 clk = ~clk;

    hdmi_tx_bringup #(
        .RST_CYC (RST), .SETTLE_CYC (SET), .ID_TRIES (TRIES), .N_PRE (NPRE),
        .PRE_TABLE (PRE), .FMT_IN (FIN), .FMT_OUT (FOUT), .AVI_BYTES (AVI),
        .SYNC_CTRL (SYNCV)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .dev_rst_n (dev_rst_n), .cmd_dev (cmd_dev),
        .cmd_offs (cmd_offs), .cmd_wdata (cmd_wdata), .cmd_rd (cmd_rd),
        .cmd_start (cmd_start), .cmd_done (cmd_done), .cmd_nack (cmd_nack),
        .cmd_rdata (cmd_rdata), .busy (busy), .done (done), .err (err),
        .err_step (err_step)
    );

    int nchk = 0, nerr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // device model
    int         bad_ids = 0, nack_at = -1, id_reads = 0, n_tx = 0, pend = 0;
    int         cur_tx = 0, overlap = 0, dev_bad = 0;
    logic [7:0] term_val = 8'h00, term_wr = 8'h00, page = 8'h00, index = 8'h00;
    logic       cur_rd = 1'b0;
    logic [7:0] cur_offs = 8'h00, cur_dat = 8'h00;
    logic       log_rd [64];
    logic [7:0] log_offs [64];
    logic [7:0] log_dat [64];

    always @(negedge clk) begin
        cmd_done = 1'b0;
        cmd_nack = 1'b0;
        if (rst_n) begin
            if (pend > 0 && cmd_start) overlap++;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    cmd_done = 1'b1;
                    cmd_nack = (cur_tx == nack_at);
                    cmd_rdata = 8'h00;
                    if (cur_rd) begin
                        if (cur_offs == 8'h1B) begin
                            id_reads++;
                            cmd_rdata = (id_reads <= bad_ids) ? 8'h00 : 8'hB4;
                        end else if (cur_offs == 8'hBE) begin
                            cmd_rdata = term_val;
                        end
                    end else if (!cmd_nack) begin
                        if (cur_offs == 8'hBC) page = cur_dat;
                        if (cur_offs == 8'hBD) index = cur_dat;
                        if (cur_offs == 8'hBE && page == 8'h01 && index == 8'h82) term_wr = cur_dat;
                    end
                end
            end else if (cmd_start) begin
                if (cmd_dev != 8'h72) dev_bad++;
                cur_tx   = n_tx;
                cur_rd   = cmd_rd;
                cur_offs = cmd_offs;
                cur_dat  = cmd_wdata;
                if (n_tx < 64) begin
                    log_rd[n_tx]   = cmd_rd;
                    log_offs[n_tx] = cmd_offs;
                    log_dat[n_tx]  = cmd_wdata;
                end
                n_tx++;
                pend = 2;
            end
        end
    end

    // expected list built from the requirements
    int         exp_n = 0;
    logic       exp_rd [64];
    logic [7:0] exp_offs [64];
    logic [7:0] exp_dat [64];
    int         exp_code [64];

    task automatic push(input logic rd, input logic [7:0] o, input logic [7:0] d, input int c);
        exp_rd[exp_n] = rd; exp_offs[exp_n] = o; exp_dat[exp_n] = d; exp_code[exp_n] = c;
        exp_n++;
    endtask

    task automatic build(input int bad, input logic [7:0] term);
        exp_n = 0;
        push(1'b0, 8'hC7, 8'h00, 1);
        for (int r = 0; r < TRIES && r <= bad; r++) push(1'b1, 8'h1B, 8'h00, 2);
        if (bad >= TRIES) return;
        push(1'b0, 8'h1E, 8'h00, 3);
        push(1'b0, 8'hBC, 8'h01, 4);
        push(1'b0, 8'hBD, 8'h82, 4);
        push(1'b1, 8'hBE, 8'h00, 4);
        push(1'b0, 8'hBE, term | 8'h01, 4);
        push(1'b0, 8'hBC, 8'h01, 5);
        push(1'b0, 8'hBD, 8'h80, 5);
        push(1'b0, 8'hBE, 8'h24, 5);
        for (int i = 0; i < NPRE; i++) push(1'b0, PRE[i*16+8 +: 8], PRE[i*16 +: 8], 6);
        push(1'b0, 8'h09, FIN, 7);
        push(1'b0, 8'h0A, FOUT, 7);
        for (int k = 0; k < 14; k++) push(1'b0, 8'h0C + 8'(k), 8'hA0 + 8'(k), 8);
        push(1'b0, 8'h63, SYNCV, 9);
    endtask

    function automatic string req_of(input int c);
        case (c)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic cmp_list(input int upto);
        int bad_at = -1;
        for (int i = 0; i < upto && i < 64; i++) begin
            if (bad_at < 0 && (log_rd[i] != exp_rd[i] || log_offs[i] != exp_offs[i] ||
                (!exp_rd[i] && log_dat[i] != exp_dat[i]))) bad_at = i;
        end
        if (bad_at >= 0)
            chk(1'b0, req_of(exp_code[bad_at]), $sformatf("command %0d offs/data", bad_at),
                {log_offs[bad_at], log_dat[bad_at]}, {exp_offs[bad_at], exp_dat[bad_at]});
        else
            chk(1'b1, "R7", "command list", 0, 0);
    endtask

    int meas_rst = 0, meas_set = 0;

    task automatic run(input int bad, input logic [7:0] term, input int nk, input bit first);
        @(negedge clk);
        rst_n = 1'b0;
        bad_ids = bad; term_val = term; nack_at = nk;
        @(negedge clk);
        n_tx = 0; id_reads = 0; overlap = 0; dev_bad = 0; term_wr = 8'h00;
        page = 8'h00; index = 8'h00;
        if (first) begin
            chk(!dev_rst_n && busy && !done && !err && !cmd_start, "R10", "reset state",
                {dev_rst_n, busy, done, err, cmd_start}, 5'b01000);
        end
        @(negedge clk);
        rst_n = 1'b1;
        meas_rst = 0;
        while (!dev_rst_n && meas_rst < 100) begin meas_rst++; @(negedge clk); end
        meas_set = 0;
        while (!cmd_start && meas_set < 100) begin meas_set++; @(negedge clk); end
        for (int w = 0; w < 3000 && !(done || err); w++) @(negedge clk);
    endtask

    task automatic check_tail(input int tx_exp);
        logic d0, e0;
        logic [3:0] s0;
        d0 = done; e0 = err; s0 = err_step;
        repeat (8) @(negedge clk);
        chk(n_tx == tx_exp, "R9", "no command after end", n_tx, tx_exp);
        chk(done == d0 && err == e0 && err_step == s0 && !busy, "R10", "end status held",
            {done, err, err_step}, {d0, e0, s0});
        chk(overlap == 0, "R8", "start while outstanding", overlap, 0);
        chk(dev_bad == 0, "R2", "device address", dev_bad, 0);
    endtask

    initial begin
        // success, immediate identity, termination preset 0x00
        build(0, 8'h00);
        run(0, 8'h00, -1, 1'b1);
        chk(meas_rst == RST, "R1", "reset low cycles", meas_rst, RST);
        chk(meas_set == SET, "R1", "settle cycles", meas_set, SET);
        chk(done && !err && err_step == 4'd0, "R10", "done status", {done, err, err_step}, 6'b100000);
        chk(n_tx == exp_n, "R7", "command count", n_tx, exp_n);
        cmp_list(exp_n);
        chk(term_wr == 8'h01, "R5", "termination write 00", term_wr, 8'h01);
        check_tail(exp_n);

        // identity succeeds on the last allowed read, termination preset 0xFE
        build(TRIES - 1, 8'hFE);
        run(TRIES - 1, 8'hFE, -1, 1'b0);
        chk(id_reads == TRIES, "R3", "identity reads on late success", id_reads, TRIES);
        chk(done && !err, "R3", "late identity completes", {done, err}, 2'b10);
        cmp_list(exp_n);
        chk(term_wr == 8'hFF, "R5", "termination write FE", term_wr, 8'hFF);
        check_tail(exp_n);

        // identity never matches
        build(TRIES, 8'h00);
        run(TRIES, 8'h00, -1, 1'b0);
        chk(id_reads == TRIES, "R3", "identity reads on exhaustion", id_reads, TRIES);
        chk(err && !done && err_step == 4'd2, "R3", "exhaustion code", {err, done, err_step}, 6'b100010);
        cmp_list(exp_n);
        check_tail(exp_n);

        // termination preset 0x81 keeps other bits
        build(1, 8'h81);
        run(1, 8'h81, -1, 1'b0);
        chk(term_wr == 8'h81, "R5", "termination write 81", term_wr, 8'h81);
        chk(meas_rst == RST && meas_set == SET, "R1", "rerun timing", {meas_rst, meas_set}, {RST, SET});
        cmp_list(exp_n);
        check_tail(exp_n);

        // ack error at every command position
        build(0, 8'h00);
        for (int t = 0; t < exp_n; t++) begin
            run(0, 8'h00, t, 1'b0);
            chk(err && !done && int'(err_step) == exp_code[t], "R9",
                $sformatf("nack at %0d code", t), err_step, exp_code[t]);
            cmp_list(t + 1);
            check_tail(t + 1);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL R10 watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule